// File: doc/BRIEF.md
# Protected Split Work-RAM Window

This block holds a 1 KB on-chip work RAM that the CPU reaches through the 4 KB page at 0x7000-0x7FFF. In that page the RAM image repeats every 1 KB. The RAM is split into a lower and an upper 512-byte half. Each half has its own read permission and its own write permission. A global enable bit gates both permissions. Once software sets the global enable, it stays set until reset.

Software controls the block through two write-only registers that sit outside the window. The mode register sits at even addresses in 0x8000-0x9FFF, and its bit 5 sets the global enable. The permission register sits at odd addresses in 0xA000-0xBFFF. When no half is readable, the block flags the window as open bus by dropping its drive flag. When a half is not readable but the other half is, reads of that half return zero with the drive flag raised.

Top module: `wram_window`

## Requirements
- R1: After a synchronous reset, the global enable is off and all four permissions are clear. A read anywhere in the window then gives rd_drive = 0 and rd_data = 0.
- R2: Only addresses 0x7000-0x7FFF reach the RAM. Address bits 11:10 are ignored, so the 1 KB image repeats four times. Reads outside the window never raise rd_drive, and writes outside the window never change the RAM.
- R3: Address bit 9 picks the half (0 = lower, 1 = upper). Bits 8:0 pick the byte within that half.
- R4: A write to an odd address in 0xA000-0xBFFF loads the permission register from data bits 7:4. Bit 7 is upper read, bit 6 is upper write, bit 5 is lower read, and bit 4 is lower write. Data bits 3:0 and writes to even addresses in that range have no effect.
- R5: When neither half is read-enabled, a read in the window gives rd_drive = 0 and rd_data = 0.
- R6: When at least one half is read-enabled, a read of a half whose read bit is clear gives rd_drive = 1 and rd_data = 0.
- R7: A CPU write stores into a half only when both the write bit and the read bit of that half are set.
- R8: A write to an even address in 0x8000-0x9FFF with data bit 5 set turns the global enable on. Later writes with bit 5 clear do not turn it off; only reset does.
- R9: While the global enable is off, the permission register stays at zero and writes to it are ignored.
- R10: A read strobe sampled at a clock edge produces rd_drive and rd_data for the following cycle. In a cycle that follows no read strobe, rd_drive is 0.
- R11: Both halves may be readable, and writable, at the same time, and each half keeps its own contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| rd_data | output | 8 | Read data, zero when not driven |
| rd_drive | output | 1 | High when the block drives the data bus |

## Verification
The hardest case to reach is a write that is refused because its half lacks read permission even though write permission is set. Nothing on the ports shows the refusal at the time of the write. The stimulus first fills a byte with a known value and then grants write-only permission to that half. It then attempts an overwrite, restores read permission, and reads the original value back. Permission writes made before the global enable is on are caught the same way: a later read must still show open bus.

// File: rtl/wram_pkg.sv
package wram_pkg;
  // permission nibble, MSB first as loaded from data bits 7:4
  typedef struct packed {
    logic hi_rd;
    logic hi_wr;
    logic lo_rd;
    logic lo_wr;
  } perm_t;

  localparam logic [3:0] WIN_PAGE   = 4'h7;   // addr[15:12] of the window
  localparam logic [2:0] MODE_GROUP = 3'b100; // addr[15:13] of the mode register
  localparam logic [2:0] PERM_GROUP = 3'b101; // addr[15:13] of the permission register
  localparam int         MODE_EN_BIT = 5;
endpackage

// File: rtl/wram_ctrl.sv
module wram_ctrl
  import wram_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_we,
  input  logic          perm_we,
  input  logic [DW-1:0] wdata,
  output logic          glob_en,
  output perm_t         perm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en <= 1'b0;
    end else if (mode_we && wdata[MODE_EN_BIT]) begin
      glob_en <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !glob_en) begin
      perm <= '0;
    end else if (perm_we) begin
      perm <= perm_t'(wdata[DW-1 -: 4]);
    end
  end

  // R8
  glob_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    glob_en |=> glob_en);

  // R9
  perm_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(glob_en) |-> perm == '0);
endmodule

// File: rtl/wram_bank.sv
module wram_bank #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    q <= mem[addr];
  end
endmodule

// File: rtl/wram_window.sv
module wram_window
  import wram_pkg::*;
#(
  parameter int HALF_AW = 9,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive
);
  localparam int NHALF = 2;

  logic                glob_en;
  perm_t               perm;
  logic                win_hit, mode_we, perm_we;
  logic                half_sel;
  logic [HALF_AW-1:0]  idx;
  logic [NHALF-1:0]    rd_ok, wr_ok, we;
  logic [DW-1:0]       q [NHALF];
  logic                drive_r, pass_r, half_r;
  logic [15-HALF_AW-1:0] unused_bits;

  assign win_hit  = cpu_addr[15:12] == WIN_PAGE;
  assign mode_we  = cpu_wr && cpu_addr[15:13] == MODE_GROUP && !cpu_addr[0];
  assign perm_we  = cpu_wr && cpu_addr[15:13] == PERM_GROUP &&  cpu_addr[0];
  assign half_sel = cpu_addr[HALF_AW];
  assign idx      = cpu_addr[HALF_AW-1:0];
  assign unused_bits = cpu_addr[15:HALF_AW+1];

  wram_ctrl #(.DW(DW)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .mode_we(mode_we),
    .perm_we(perm_we),
    .wdata  (cpu_wdata),
    .glob_en(glob_en),
    .perm   (perm)
  );

  assign rd_ok = {perm.hi_rd, perm.lo_rd};
  assign wr_ok = {perm.hi_wr, perm.lo_wr};

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign we[h] = cpu_wr && win_hit && (half_sel == h[0]) && rd_ok[h] && wr_ok[h];
    wram_bank #(.AW(HALF_AW), .DW(DW)) u_bank (
      .clk (clk),
      .we  (we[h]),
      .addr(idx),
      .wd  (cpu_wdata),
      .q   (q[h])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_r <= 1'b0;
      pass_r  <= 1'b0;
      half_r  <= 1'b0;
    end else begin
      drive_r <= cpu_rd && win_hit && (|rd_ok);
      pass_r  <= rd_ok[half_sel];
      half_r  <= half_sel;
    end
  end

  assign rd_drive = drive_r;
  assign rd_data  = (drive_r && pass_r) ? q[half_r] : '0;

  // R10
  drive_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rd_drive |-> $past(cpu_rd && win_hit));

  // R5
  quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_drive |-> rd_data == '0);

  // R7
  no_perm_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && win_hit && !glob_en) |-> we == '0);
endmodule

// File: tb/wram_window_tb.sv
module wram_window_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  rd_data;
  logic        rd_drive;
  int          n_chk = 0;
  int          n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  wram_window u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  // {is_read, addr, wdata, exp_drive, exp_data, req}
  localparam int NV = 35;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 16'hA001, 8'hF0, 1'b0, 8'h00, 8'd9 },  // R9 permission write while disabled
    {1'b1, 16'h7005, 8'h00, 1'b0, 8'h00, 8'd9 },  // R9 still open bus
    {1'b0, 16'h8000, 8'h20, 1'b0, 8'h00, 8'd8 },  // R8 global enable on
    {1'b0, 16'h8000, 8'h00, 1'b0, 8'h00, 8'd8 },  // R8 bit 5 clear, stays on
    {1'b0, 16'hA001, 8'h3F, 1'b0, 8'h00, 8'd4 },  // R4 lower r/w, low nibble ignored
    {1'b0, 16'h7005, 8'h5A, 1'b0, 8'h00, 8'd7 },
    {1'b1, 16'h7005, 8'h00, 1'b1, 8'h5A, 8'd7 },  // R7 stored
    {1'b1, 16'h7205, 8'h00, 1'b1, 8'h00, 8'd6 },  // R6 upper unreadable
    {1'b0, 16'hA001, 8'hC0, 1'b0, 8'h00, 8'd4 },  // R4 upper r/w only
    {1'b0, 16'h7210, 8'hA5, 1'b0, 8'h00, 8'd3 },
    {1'b1, 16'h7210, 8'h00, 1'b1, 8'hA5, 8'd3 },  // R3 upper half
    {1'b1, 16'h7005, 8'h00, 1'b1, 8'h00, 8'd6 },  // R6 lower unreadable
    {1'b0, 16'hA001, 8'hA0, 1'b0, 8'h00, 8'd4 },  // both read, no write
    {1'b0, 16'h7005, 8'hFF, 1'b0, 8'h00, 8'd7 },
    {1'b0, 16'h7210, 8'h00, 1'b0, 8'h00, 8'd7 },
    {1'b1, 16'h7005, 8'h00, 1'b1, 8'h5A, 8'd7 },  // R7 write refused
    {1'b1, 16'h7210, 8'h00, 1'b1, 8'hA5, 8'd11},  // R11 both readable
    {1'b1, 16'h7C05, 8'h00, 1'b1, 8'h5A, 8'd2 },  // R2 mirror
    {1'b0, 16'hA001, 8'h10, 1'b0, 8'h00, 8'd7 },  // lower write-only
    {1'b0, 16'h7005, 8'h11, 1'b0, 8'h00, 8'd7 },
    {1'b1, 16'h7005, 8'h00, 1'b0, 8'h00, 8'd5 },  // R5 open bus
    {1'b0, 16'hA001, 8'hF0, 1'b0, 8'h00, 8'd11},  // both r/w
    {1'b1, 16'h7005, 8'h00, 1'b1, 8'h5A, 8'd7 },  // R7 write-only refused
    {1'b0, 16'h7401, 8'h77, 1'b0, 8'h00, 8'd2 },
    {1'b1, 16'h7001, 8'h00, 1'b1, 8'h77, 8'd2 },  // R2 mirror write
    {1'b0, 16'h7FFF, 8'h3C, 1'b0, 8'h00, 8'd3 },
    {1'b1, 16'h73FF, 8'h00, 1'b1, 8'h3C, 8'd3 },  // R3 top index
    {1'b1, 16'h6005, 8'h00, 1'b0, 8'h00, 8'd2 },  // R2 below window
    {1'b1, 16'h8005, 8'h00, 1'b0, 8'h00, 8'd2 },  // R2 above window
    {1'b0, 16'hA000, 8'h00, 1'b0, 8'h00, 8'd4 },  // even address, no effect
    {1'b1, 16'h7005, 8'h00, 1'b1, 8'h5A, 8'd4 },  // R4
    {1'b0, 16'h6005, 8'h99, 1'b0, 8'h00, 8'd2 },
    {1'b0, 16'hF005, 8'h98, 1'b0, 8'h00, 8'd2 },
    {1'b1, 16'h7005, 8'h00, 1'b1, 8'h5A, 8'd2 },  // R2 outside writes ignored
    {1'b1, 16'h7001, 8'h00, 1'b1, 8'h77, 8'd11}   // R11
  };

  task automatic check(input string req, input logic xd, input logic [7:0] xq);
    n_chk++;
    if (rd_drive !== xd || rd_data !== xq) begin
      n_err++;
      $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
               req, rd_drive, rd_data, xd, xq);
    end
  endtask

  // one access: drive at negedge, result visible at the next negedge
  task automatic access(input logic rd, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = ~rd;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1", 1'b0, 8'h00);
    access(1'b1, 16'h7200, 8'h00);
    check("R1", 1'b0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][41], VEC[i][40:25], VEC[i][24:17]);
      if (VEC[i][41]) check($sformatf("R%0d", VEC[i][7:0]), VEC[i][16], VEC[i][15:8]);
    end

    // R10 drive lasts only for the cycle after the read strobe
    access(1'b1, 16'h7005, 8'h00);
    check("R10", 1'b1, 8'h5A);
    @(negedge clk);
    check("R10", 1'b0, 8'h00);

    // R1 reset mid-run clears the global enable and permissions
    do_reset();
    access(1'b1, 16'h7005, 8'h00);
    check("R1", 1'b0, 8'h00);
    access(1'b0, 16'hA001, 8'hF0);
    access(1'b1, 16'h7005, 8'h00);
    check("R9", 1'b0, 8'h00);

    // R8 mode write without bit 5 does not enable
    access(1'b0, 16'h8000, 8'hDF);
    access(1'b0, 16'hA001, 8'hF0);
    access(1'b1, 16'h7005, 8'h00);
    check("R8", 1'b0, 8'h00);
    access(1'b0, 16'h9FFE, 8'h20);
    access(1'b0, 16'hBFFF, 8'h20);
    access(1'b1, 16'h7205, 8'h00);
    check("R8", 1'b1, 8'h00);
    access(1'b1, 16'h7005, 8'h00);
    check("R8", 1'b1, 8'h5A);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule